// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes charge of a synchronous DRAM's command pins from reset until the memory is ready for normal use. It keeps the clock enable and the data masks high and presents a no-operation command for a long settling interval. It then issues one precharge of every bank, a series of spaced auto-refresh commands and finally a mode register load. When the settle time after that load has passed, it raises a done flag. A normal memory controller watches the flag and takes over the pins.

All timing gaps are counted in clock cycles and set by parameters: the settling interval, the precharge recovery, the refresh cycle time, the mode-load settle time and the number of refreshes. A fast-simulation switch replaces the long settling count with a short one. The word to load into the mode register comes in on an input port.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is high, the command pins show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), cke is 1, every dqm bit is 1 and init_done is 0.
- R2: Count rising edges from the first edge with reset low as edge 0. Through edge W-1, the pins hold NOP with cke and dqm high. W is WAIT_CYC, or FAST_WAIT when FAST_SIM is 1.
- R3: After edge W the pins carry precharge (cs_n=0, ras_n=0, cas_n=1, we_n=0) for one cycle, with addr bit 10 high, every other addr bit 0 and ba 0.
- R4: The first auto-refresh (cs_n=0, ras_n=0, cas_n=0, we_n=1) appears TRP_CYC cycles after the precharge. NUM_REF refreshes (at least 8) follow, each TRFC_CYC cycles after the one before.
- R5: The mode register load (all four command pins 0) appears TRFC_CYC cycles after the last refresh. It carries addr = mode_word[11:0] with bits 9 to 7 forced to 0, and ba = mode_word[13:12].
- R6: Every cycle that is not one of the commands above is NOP, and cke and all dqm bits stay high for the whole sequence and after it.
- R7: init_done rises TRSC_CYC+1 cycles after the mode load cycle and stays high until reset. The pins show NOP from then on.
- R8: A reset asserted at any point restarts the sequence from the wait phase, with the same timing as after the first reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_word | input | 14 | Bits 11:0 to addr, bits 13:12 to ba at the mode load |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| dqm | output | 2 | Data mask bits |
| addr | output | 12 | Address pins |
| ba | output | 2 | Bank select pins |
| init_done | output | 1 | Sequence complete, sticky until reset |

## Verification
The hardest case to reach from the ports is a reset that arrives in the middle of the sequence, such as between two refreshes or just before the mode load. The sequencer must then drop all of its progress and repeat the whole timing from the wait phase. The bench reaches this case by running the sequence up to a randomly chosen cycle, pulsing reset, and then checking a complete new run cycle by cycle. Random mode words, together with all-ones and all-zeros words, show that bits 9 to 7 are cleared and that the other bits reach addr and ba.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

  typedef enum logic [2:0] {
    PH_WAIT, PH_PRE, PH_REF, PH_MRS, PH_DONE
  } phase_t;

  typedef enum logic [1:0] {
    OP_NOP, OP_PRE, OP_REF, OP_MRS
  } op_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PINS_NOP = 4'b0111;
  localparam logic [3:0] PINS_PRE = 4'b0010;
  localparam logic [3:0] PINS_REF = 4'b0001;
  localparam logic [3:0] PINS_MRS = 4'b0000;

  function automatic logic [3:0] op_pins(op_t o);
    case (o)
      OP_PRE:  return PINS_PRE;
      OP_REF:  return PINS_REF;
      OP_MRS:  return PINS_MRS;
      default: return PINS_NOP;
    endcase
  endfunction

endpackage

// File: rtl/sdram_boot_timer.sv
module sdram_boot_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] rst_val,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)        cnt <= rst_val;
    else if (load)  cnt <= load_val;
    else if (!zero) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R2: an expired gap stays expired until the sequencer reloads it
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (zero && !load) |=> zero);

endmodule

// File: rtl/sdram_boot_fsm.sv
module sdram_boot_fsm
  import sdram_boot_pkg::*;
#(
  parameter int NUM_REF  = 8,
  parameter int CW       = 8,
  parameter int TRP_CYC  = 3,
  parameter int TRFC_CYC = 10,
  parameter int TRSC_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          zero,
  output logic          load,
  output logic [CW-1:0] load_val,
  output op_t           op,
  output logic          finish
);
  localparam int RW = $clog2(NUM_REF + 1);
  localparam logic [CW-1:0] LV_TRP  = CW'(TRP_CYC - 1);
  localparam logic [CW-1:0] LV_TRFC = CW'(TRFC_CYC - 1);
  localparam logic [CW-1:0] LV_TRSC = CW'(TRSC_CYC);
  localparam logic [RW-1:0] REF_LAST = RW'(NUM_REF);

  phase_t        phase, phase_nx;
  logic [RW-1:0] ref_n, ref_nx;

  always_comb begin
    phase_nx = phase;
    ref_nx   = ref_n;
    load     = 1'b0;
    load_val = '0;
    op       = OP_NOP;
    finish   = 1'b0;
    if (zero) begin
      case (phase)
        PH_WAIT: begin
          op = OP_PRE; load = 1'b1; load_val = LV_TRP; phase_nx = PH_PRE;
        end
        PH_PRE: begin
          op = OP_REF; load = 1'b1; load_val = LV_TRFC; phase_nx = PH_REF;
          ref_nx = RW'(1);
        end
        PH_REF: begin
          load = 1'b1;
          if (ref_n == REF_LAST) begin
            op = OP_MRS; load_val = LV_TRSC; phase_nx = PH_MRS;
          end else begin
            op = OP_REF; load_val = LV_TRFC; ref_nx = ref_n + 1'b1;
          end
        end
        PH_MRS: begin
          finish = 1'b1; phase_nx = PH_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_WAIT;
      ref_n <= '0;
    end else begin
      phase <= phase_nx;
      ref_n <= ref_nx;
    end
  end

  // R4: the refresh tally never passes the programmed number
  a_r4_ref_bound: assert property (@(posedge clk) disable iff (rst)
    ref_n <= REF_LAST);
  // R7: once finished, the sequencer never leaves the done phase
  a_r7_done_phase: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DONE) |=> (phase == PH_DONE));

endmodule

// File: rtl/sdram_boot_drive.sv
module sdram_boot_drive
  import sdram_boot_pkg::*;
#(
  parameter int ROW_W    = 12,
  parameter int BANK_W   = 2,
  parameter int DQM_W    = 2,
  parameter int AP_BIT   = 10,
  parameter int ZLO      = 7,
  parameter int ZHI      = 9,
  parameter int NUM_REF  = 8,
  parameter int TRFC_CYC = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  op_t                     op,
  input  logic                    finish,
  input  logic [ROW_W+BANK_W-1:0] mode_word,
  output logic [3:0]              cmd_pins,
  output logic                    cke,
  output logic [DQM_W-1:0]        dqm,
  output logic [ROW_W-1:0]        addr,
  output logic [BANK_W-1:0]       ba,
  output logic                    done
);
  localparam logic [ROW_W-1:0] AP_MASK = ROW_W'(1) << AP_BIT;
  localparam logic [ROW_W-1:0] Z_MASK  =
    ((ROW_W'(1) << (ZHI + 1)) - ROW_W'(1)) ^ ((ROW_W'(1) << ZLO) - ROW_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_pins <= PINS_NOP;
      cke      <= 1'b1;
      dqm      <= '1;
      addr     <= '0;
      ba       <= '0;
      done     <= 1'b0;
    end else begin
      cmd_pins <= op_pins(op);
      cke      <= 1'b1;
      dqm      <= '1;
      done     <= done | finish;
      case (op)
        OP_PRE: begin addr <= AP_MASK; ba <= '0; end
        OP_MRS: begin
          addr <= mode_word[ROW_W-1:0] & ~Z_MASK;
          ba   <= mode_word[ROW_W +: BANK_W];
        end
        default: begin addr <= '0; ba <= '0; end
      endcase
    end
  end

  // Observation of the pins for the assertions below
  localparam int GW = $clog2(TRFC_CYC + 2);
  localparam int SW = $clog2(NUM_REF + 2);
  logic          pre_seen, mrs_seen;
  logic [SW-1:0] refs_seen;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_seen  <= 1'b0;
      mrs_seen  <= 1'b0;
      refs_seen <= '0;
      gap       <= '0;
    end else begin
      if (cmd_pins == PINS_PRE) pre_seen <= 1'b1;
      if (cmd_pins == PINS_MRS) mrs_seen <= 1'b1;
      if (cmd_pins == PINS_REF) begin
        gap <= GW'(1);
        if (refs_seen != '1) refs_seen <= refs_seen + 1'b1;
      end else if (gap != '0 && gap != GW'(TRFC_CYC)) begin
        gap <= gap + 1'b1;
      end
    end
  end

  a_r3_pre_first: assert property (@(posedge clk) disable iff (rst)
    (!pre_seen && cmd_pins != PINS_NOP) |-> (cmd_pins == PINS_PRE));
  a_r4_ref_gap: assert property (@(posedge clk) disable iff (rst)
    (cmd_pins == PINS_REF && refs_seen != '0) |-> (gap == GW'(TRFC_CYC)));
  a_r5_mrs_after_refs: assert property (@(posedge clk) disable iff (rst)
    (cmd_pins == PINS_MRS) |-> (refs_seen >= SW'(NUM_REF)));
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  a_r7_done_after_mrs: assert property (@(posedge clk) disable iff (rst)
    done |-> mrs_seen);

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int WAIT_CYC  = 26667,
  parameter bit FAST_SIM  = 1'b0,
  parameter int FAST_WAIT = 100,
  parameter int TRP_CYC   = 3,
  parameter int TRFC_CYC  = 10,
  parameter int TRSC_CYC  = 2,
  parameter int NUM_REF   = 8,
  parameter int ROW_W     = 12,
  parameter int BANK_W    = 2,
  parameter int DQM_W     = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ROW_W+BANK_W-1:0] mode_word,
  output logic                    cs_n,
  output logic                    ras_n,
  output logic                    cas_n,
  output logic                    we_n,
  output logic                    cke,
  output logic [DQM_W-1:0]        dqm,
  output logic [ROW_W-1:0]        addr,
  output logic [BANK_W-1:0]       ba,
  output logic                    init_done
);
  localparam int W_EFF = FAST_SIM ? FAST_WAIT : WAIT_CYC;
  localparam int M1    = (W_EFF > TRFC_CYC) ? W_EFF : TRFC_CYC;
  localparam int M2    = (TRP_CYC > TRSC_CYC) ? TRP_CYC : TRSC_CYC;
  localparam int MAXV  = (M1 > M2) ? M1 : M2;
  localparam int CW    = $clog2(MAXV + 1);

  logic          zero, load, finish;
  logic [CW-1:0] load_val;
  op_t           op;
  logic [3:0]    cmd_pins;

  sdram_boot_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .rst_val(CW'(W_EFF)),
    .load(load), .load_val(load_val), .zero(zero)
  );

  sdram_boot_fsm #(
    .NUM_REF(NUM_REF), .CW(CW), .TRP_CYC(TRP_CYC),
    .TRFC_CYC(TRFC_CYC), .TRSC_CYC(TRSC_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .zero(zero), .load(load),
    .load_val(load_val), .op(op), .finish(finish)
  );

  sdram_boot_drive #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .DQM_W(DQM_W), .AP_BIT(10),
    .ZLO(7), .ZHI(9), .NUM_REF(NUM_REF), .TRFC_CYC(TRFC_CYC)
  ) u_drive (
    .clk(clk), .rst(rst), .op(op), .finish(finish), .mode_word(mode_word),
    .cmd_pins(cmd_pins), .cke(cke), .dqm(dqm), .addr(addr), .ba(ba),
    .done(init_done)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd_pins;

endmodule

// File: tb/test_sdram_boot_seq.sv
`timescale 1ns/1ps
module test_sdram_boot_seq;
  localparam int W    = 40;
  localparam int TRP  = 3;
  localparam int TRFC = 7;
  localparam int TRSC = 2;
  localparam int NREF = 8;
  localparam int P    = W;
  localparam int M    = P + TRP + NREF * TRFC;
  localparam int LAST = M + TRSC + 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [13:0] mode_word = '0;
  logic cs_n, ras_n, cas_n, we_n, cke, init_done;
  logic [1:0] dqm, ba;
  logic [11:0] addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  sdram_boot_seq #(
    .WAIT_CYC(26667), .FAST_SIM(1'b1), .FAST_WAIT(W), .TRP_CYC(TRP),
    .TRFC_CYC(TRFC), .TRSC_CYC(TRSC), .NUM_REF(NREF)
  ) i_sdram_boot_seq (
    .clk(clk), .rst(rst), .mode_word(mode_word), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .cke(cke), .dqm(dqm), .addr(addr), .ba(ba),
    .init_done(init_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_cmd(input int i);
    int k;
    if (i == P) return 4'b0010;
    if (i == M) return 4'b0000;
    k = i - P - TRP;
    if (k >= 0 && (k % TRFC) == 0 && (k / TRFC) < NREF) return 4'b0001;
    return 4'b0111;
  endfunction

  function automatic string req_of(input int i, input logic [3:0] c);
    if (c == 4'b0010) return "R3";
    if (c == 4'b0001) return "R4";
    if (c == 4'b0000) return "R5";
    if (i < P) return "R2";
    return "R6";
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", "reset cmd",
          {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    check(cke === 1'b1 && dqm === 2'b11, "R1", "reset cke/dqm", {cke, dqm}, 3'b111);
    check(init_done === 1'b0, "R1", "reset done", init_done, 0);
    rst = 1'b0;
  endtask

  // runs periods 0..stop-1 after reset release, checking each one
  task automatic run_seq(input int stop, input logic [13:0] mw);
    logic [3:0] ec;
    logic [11:0] ea;
    logic [1:0] eb;
    string rq;
    for (int i = 0; i < stop; i++) begin
      @(negedge clk);
      ec = exp_cmd(i);
      rq = req_of(i, ec);
      check({cs_n, ras_n, cas_n, we_n} == ec, rq, "command",
            {cs_n, ras_n, cas_n, we_n}, ec);
      check(cke === 1'b1 && dqm === 2'b11, (i < P) ? "R2" : "R6", "cke/dqm",
            {cke, dqm}, 3'b111);
      if (ec == 4'b0010 || ec == 4'b0000) begin
        ea = (ec == 4'b0010) ? 12'h400 : (mw[11:0] & 12'hC7F);
        eb = (ec == 4'b0010) ? 2'b00 : mw[13:12];
        check(addr == ea, rq, "addr", addr, ea);
        check(ba == eb, rq, "ba", ba, eb);
      end
      check(init_done == (i >= M + TRSC + 1), "R7", "init_done",
            init_done, (i >= M + TRSC + 1));
    end
  endtask

  initial begin
    logic [13:0] mw;
    int cut;
    void'($urandom(32'h5D2A));
    mode_word = 14'h3FFF;
    do_reset();
    run_seq(LAST, mode_word);
    mode_word = 14'h0000;
    do_reset();
    run_seq(LAST, mode_word);
    for (int t = 0; t < 4; t++) begin
      mw = 14'($urandom);
      mode_word = mw;
      do_reset();
      cut = P / 2 + int'($urandom % (M - P / 2 + 3));
      run_seq(cut, mw);
      // R8: mid-sequence reset, then a whole new run must follow
      do_reset();
      mw = 14'($urandom);
      mode_word = mw;
      run_seq(P, mw);
      @(negedge clk);
      check({cs_n, ras_n, cas_n, we_n} == 4'b0010 && addr == 12'h400, "R8",
            "restart precharge", {cs_n, ras_n, cas_n, we_n}, 4'b0010);
      repeat (M - P) @(negedge clk);
      check({cs_n, ras_n, cas_n, we_n} == 4'b0000, "R8", "restart mode load",
            {cs_n, ras_n, cas_n, we_n}, 4'b0000);
      check(addr == (mw[11:0] & 12'hC7F) && ba == mw[13:12], "R8",
            "restart mode word", {ba, addr}, {mw[13:12], mw[11:0] & 12'hC7F});
      repeat (TRSC + 1) @(negedge clk);
      check(init_done === 1'b1, "R8", "restart done", init_done, 1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule